// File: doc/BRIEF.md
# Hashed Multibank Memory Front End

This block takes a stream of word-sized memory references and spreads them over many independent storage banks. Every bank needs several clock cycles to serve one reference. The block turns each byte address into a word address. It then passes that word address through a reversible bit mix, which yields a bank number and a slot inside that bank. Because of this mix, regular access patterns land on many banks and do not queue up behind one bank. Power-of-two strides are the main case this protects against.

Requests enter on a valid/ready channel, at most one per clock. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` depends only on the bank that the presented address hashes to: it drops while that bank's input queue is full. Once the master has raised `req_valid`, it must hold the request stable until the handshake. Each bank serves its queue in order, so two references to the same word complete in the order they were accepted. References to different banks finish independently, so responses may come back out of order. Every response carries the tag of the request it answers. Responses leave on a second valid/ready channel. While `rsp_ready` is low, the offered response stays fixed.

Top module: `mbank_front`

## Requirements
- R1: Only bits [ADDR_W-1:3] of `req_addr` select a word. The three byte-offset bits have no effect on which word is read or written.
- R2: Let the word address be w, split into low = w[BANK_W-1:0] and high = the remaining upper bits. The slot inside the bank is high. The bank index is low with each bit j of high XORed into bank bit (j mod BANK_W). Distinct word addresses therefore never share a storage location.
- R3: Sixteen back-to-back reads at a word stride of 32 hit sixteen different banks. With `rsp_ready` held high, the last of their responses arrives at most 2*BUSY_CYCLES+16 cycles after the first request is accepted.
- R4: At most one request is accepted per clock, on `req_valid && req_ready`. When the target banks have room, requests are accepted in consecutive cycles. After reset `req_ready` is high and `rsp_valid` is low.
- R5: Each bank holds up to FIFO_DEPTH waiting requests in addition to the one it is serving. Once these are taken, `req_ready` is low for any request aimed at that bank.
- R6: Suppose a request goes to an idle bank while no other response is pending and `rsp_ready` is high. Its response is first visible after the (BUSY_CYCLES+1)-th rising edge that follows acceptance.
- R7: A bank starts a new access no sooner than BUSY_CYCLES cycles after starting its previous access. The responses of two requests to the same bank are therefore at least BUSY_CYCLES cycles apart.
- R8: `rsp_tag` equals the `req_tag` of the request being answered. A request to an idle bank may be answered before an earlier-accepted request that waits behind a busy bank.
- R9: A read response returns the data of the most recent accepted write to that word, or zero if the word has not been written since reset. A write response has `rsp_write` = 1 and echoes the written data. A read response has `rsp_write` = 0.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_tag`, `rsp_write` and `rsp_rdata` stay unchanged into the next cycle.
- R11: When several banks hold finished results, the arbiter searches round-robin. It starts at the bank after the one granted last, and bank 0 comes first after reset. Once a result is offered while `rsp_ready` is low, that same result stays offered until it is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Target bank queue has room |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_tag | input | TAG_W | Request identifier, returned with the response |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_write | output | 1 | Response answers a write |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_rdata | output | DATA_W | Read data, or echoed write data |

## Verification
The bench tries several address patterns, and each one separates a different fault. A stride-32 burst of reads would stall if the bank mix were missing. A set of addresses that all share one bank shows the queue depth and the back-pressure point. A same-bank pair followed by an other-bank request exposes any in-order completion. A complete write-then-read sweep of every word proves that no two addresses alias. After these, random traffic with random response back-pressure is compared against a word-level model by tag. A directed arbitration case uses three held results and a known last grant, so that round-robin order can be told apart from fixed priority.

// File: rtl/mbank_pkg.sv
package mbank_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;
endpackage

// File: rtl/mbank_hash.sv
module mbank_hash #(
  parameter int WORD_W = 9,
  parameter int BANK_W = 7
) (
  input  logic [WORD_W-1:0]        word,
  output logic [BANK_W-1:0]        bank,
  output logic [WORD_W-BANK_W-1:0] slot
);
  localparam int SLOT_W = WORD_W - BANK_W;

  always_comb begin
    slot = word[WORD_W-1:BANK_W];
    bank = word[BANK_W-1:0];
    for (int j = 0; j < SLOT_W; j++) begin
      bank[j % BANK_W] = bank[j % BANK_W] ^ slot[j];
    end
  end
endmodule

// File: rtl/mbank_rr_arb.sv
module mbank_rr_arb #(
  parameter int N = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 take,
  output logic                 any,
  output logic [$clog2(N)-1:0] sel
);
  localparam int IDX_W = $clog2(N);

  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] rr_idx;
  logic [IDX_W-1:0] lock_idx;
  logic             locked;
  logic             found;

  always_comb begin
    rr_idx = ptr;
    found  = 1'b0;
    for (int i = 1; i <= N; i++) begin
      if (!found && req[(int'(ptr) + i) % N]) begin
        found  = 1'b1;
        rr_idx = IDX_W'((int'(ptr) + i) % N);
      end
    end
  end

  assign any = |req;
  assign sel = locked ? lock_idx : rr_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= IDX_W'(N - 1);
      locked   <= 1'b0;
      lock_idx <= '0;
    end else begin
      if (take) ptr <= sel;
      locked   <= any && !take;
      lock_idx <= sel;
    end
  end

  // R11: a selected requester is really requesting
  a_r11_sel_valid: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[sel]);

  // R11: the same bank is granted twice in a row only when it was alone
  a_r11_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (take && $past(take) && sel == $past(sel)) |-> $countones(req) == 1);

  // R11: a stalled offer stays on the same requester
  a_r11_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (any && !take) |=> (sel == $past(sel)));
endmodule

// File: rtl/mbank_bank.sv
module mbank_bank
  import mbank_pkg::*;
#(
  parameter int SLOT_W = 2,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 8,
  parameter int DEPTH  = 4,
  parameter int BUSY   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              push_write,
  input  logic [SLOT_W-1:0] push_slot,
  input  logic [DATA_W-1:0] push_data,
  input  logic [TAG_W-1:0]  push_tag,
  output logic              full,
  output logic              done,
  output logic              done_write,
  output logic [TAG_W-1:0]  done_tag,
  output logic [DATA_W-1:0] done_data,
  input  logic              gnt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int WORDS = 1 << SLOT_W;
  localparam int TMR_W = $clog2(BUSY + 1);

  op_e               q_op   [DEPTH];
  logic [SLOT_W-1:0] q_slot [DEPTH];
  logic [DATA_W-1:0] q_data [DEPTH];
  logic [TAG_W-1:0]  q_tag  [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  count;

  logic [DATA_W-1:0] mem [WORDS];

  logic              busy;
  logic [TMR_W-1:0]  tmr;
  op_e               cur_op;
  logic [SLOT_W-1:0] cur_slot;
  logic [DATA_W-1:0] cur_data;
  logic [TAG_W-1:0]  cur_tag;

  logic pop;

  assign full = (int'(count) == DEPTH);
  assign pop  = !busy && (count != '0) && (!done || gnt);

  // request queue
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        q_op[wptr]   <= op_e'(push_write);
        q_slot[wptr] <= push_slot;
        q_data[wptr] <= push_data;
        q_tag[wptr]  <= push_tag;
        wptr <= (int'(wptr) == DEPTH - 1) ? '0 : wptr + 1'b1;
      end
      if (pop) begin
        rptr <= (int'(rptr) == DEPTH - 1) ? '0 : rptr + 1'b1;
      end
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // access engine and storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      tmr        <= '0;
      cur_op     <= OP_READ;
      cur_slot   <= '0;
      cur_data   <= '0;
      cur_tag    <= '0;
      done       <= 1'b0;
      done_write <= 1'b0;
      done_tag   <= '0;
      done_data  <= '0;
      for (int k = 0; k < WORDS; k++) mem[k] <= '0;
    end else begin
      if (pop) begin
        busy     <= 1'b1;
        tmr      <= TMR_W'(BUSY - 1);
        cur_op   <= q_op[rptr];
        cur_slot <= q_slot[rptr];
        cur_data <= q_data[rptr];
        cur_tag  <= q_tag[rptr];
      end else if (busy) begin
        if (tmr == '0) begin
          busy <= 1'b0;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end

      if (busy && tmr == '0) begin
        done       <= 1'b1;
        done_write <= (cur_op == OP_WRITE);
        done_tag   <= cur_tag;
        if (cur_op == OP_WRITE) begin
          mem[cur_slot] <= cur_data;
          done_data     <= cur_data;
        end else begin
          done_data     <= mem[cur_slot];
        end
      end else if (gnt) begin
        done <= 1'b0;
      end
    end
  end

  // spacing monitor for starts of accesses
  logic [TMR_W-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap <= TMR_W'(BUSY);
    end else if (pop) begin
      gap <= TMR_W'(1);
    end else if (int'(gap) < BUSY) begin
      gap <= gap + 1'b1;
    end
  end

  // R7: accesses on one bank start at least BUSY cycles apart
  a_r7_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> int'(gap) >= BUSY);

  // R5: the queue is never written while full
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R10: a finished result is only dropped after a grant
  a_r10_keep_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !gnt) |=> done && $stable(done_tag) && $stable(done_data));
endmodule

// File: rtl/mbank_front.sv
module mbank_front #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 64,
  parameter int TAG_W       = 8,
  parameter int BANK_W      = 7,
  parameter int FIFO_DEPTH  = 4,
  parameter int BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_write,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int NB     = 1 << BANK_W;
  localparam int WORD_W = ADDR_W - 3;
  localparam int SLOT_W = WORD_W - BANK_W;

  logic [WORD_W-1:0] word;
  logic [BANK_W-1:0] tgt_bank;
  logic [SLOT_W-1:0] tgt_slot;

  logic [NB-1:0]     bank_full;
  logic [NB-1:0]     bank_done;
  logic [NB-1:0]     bank_dwr;
  logic [TAG_W-1:0]  bank_tag  [NB];
  logic [DATA_W-1:0] bank_data [NB];

  logic              any_done;
  logic [BANK_W-1:0] sel;
  logic              take;
  logic              accept;

  assign word = req_addr[ADDR_W-1:3];

  mbank_hash #(.WORD_W(WORD_W), .BANK_W(BANK_W)) hash_i (
    .word (word),
    .bank (tgt_bank),
    .slot (tgt_slot)
  );

  assign req_ready = !bank_full[tgt_bank];
  assign accept    = req_valid && req_ready;
  assign take      = rsp_valid && rsp_ready;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    mbank_bank #(
      .SLOT_W (SLOT_W),
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W),
      .DEPTH  (FIFO_DEPTH),
      .BUSY   (BUSY_CYCLES)
    ) bank_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (accept && (tgt_bank == BANK_W'(b))),
      .push_write (req_write),
      .push_slot  (tgt_slot),
      .push_data  (req_wdata),
      .push_tag   (req_tag),
      .full       (bank_full[b]),
      .done       (bank_done[b]),
      .done_write (bank_dwr[b]),
      .done_tag   (bank_tag[b]),
      .done_data  (bank_data[b]),
      .gnt        (take && (sel == BANK_W'(b)))
    );
  end

  mbank_rr_arb #(.N(NB)) arb_i (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (bank_done),
    .take  (take),
    .any   (any_done),
    .sel   (sel)
  );

  assign rsp_valid = any_done;
  assign rsp_write = bank_dwr[sel];
  assign rsp_tag   = bank_tag[sel];
  assign rsp_rdata = bank_data[sel];

  // R10: a stalled response holds still
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      rsp_valid && $stable(rsp_tag) && $stable(rsp_rdata) && $stable(rsp_write));

  // R5: a full target bank always shows back-pressure
  a_r5_stall: assert property (@(posedge clk) disable iff (!rst_n)
    bank_full[tgt_bank] |-> !req_ready);
endmodule

// File: tb/mbank_front_tb_top.sv
module mbank_front_tb_top;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 64;
  localparam int TAG_W  = 8;
  localparam int BUSY   = 16;
  localparam int NWORDS = 1 << (ADDR_W - 3);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [TAG_W-1:0]  req_tag = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic              rsp_write;
  logic [TAG_W-1:0]  rsp_tag;
  logic [DATA_W-1:0] rsp_rdata;

  always #2 clk = ~clk;

  mbank_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
                .BANK_W(7), .FIFO_DEPTH(4), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_write(rsp_write),
    .rsp_tag(rsp_tag), .rsp_rdata(rsp_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int seqn   = 0;
  int rdy_mode = 0;   // 0 always ready, 1 never, 2 random

  logic [DATA_W-1:0] model [NWORDS];
  bit                pend     [256];
  bit                exp_wr   [256];
  logic [DATA_W-1:0] exp_data [256];
  logic [DATA_W-1:0] got_data [256];
  int                acc_cyc  [256];
  int                rsp_cyc  [256];
  int                rsp_seq  [256];
  logic [TAG_W-1:0]  next_tag = '0;
  logic [TAG_W-1:0]  last_tag;

  bit                held = 0;
  logic [TAG_W-1:0]  held_tag;
  logic [DATA_W-1:0] held_data;
  bit                held_wr;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int outstanding();
    int n = 0;
    for (int i = 0; i < 256; i++) if (pend[i]) n++;
    return n;
  endfunction

  // response monitor and rsp_ready driver
  always @(negedge clk) begin
    case (rdy_mode)
      0: rsp_ready = 1'b1;
      1: rsp_ready = 1'b0;
      default: rsp_ready = ($urandom % 4) != 0;
    endcase
    #1;
    if (rst_n) begin
      if (held) begin
        chk(rsp_valid && rsp_tag == held_tag && rsp_rdata == held_data &&
            rsp_write == held_wr, "R10", "held response",
            {rsp_tag, rsp_rdata[55:0]}, {held_tag, held_data[55:0]});
      end
      if (rsp_valid) begin
        if (rsp_ready) begin
          held = 0;
          chk(pend[rsp_tag], "R8", "tag of response is outstanding",
              64'(rsp_tag), 64'(rsp_tag));
          chk(rsp_write == exp_wr[rsp_tag] && rsp_rdata == exp_data[rsp_tag],
              "R9", "response data", rsp_rdata, exp_data[rsp_tag]);
          pend[rsp_tag]     = 0;
          got_data[rsp_tag] = rsp_rdata;
          rsp_cyc[rsp_tag]  = cyc;
          rsp_seq[rsp_tag]  = seqn;
          seqn++;
        end else begin
          held      = 1;
          held_tag  = rsp_tag;
          held_data = rsp_rdata;
          held_wr   = rsp_write;
        end
      end else begin
        held = 0;
      end
    end
  end

  task automatic issue(input bit wr, input int w, input logic [DATA_W-1:0] d,
                       input logic [2:0] low);
    while (pend[next_tag]) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {w[ADDR_W-4:0], low};
    req_wdata = d;
    req_tag   = next_tag;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    pend[next_tag]     = 1;
    exp_wr[next_tag]   = wr;
    exp_data[next_tag] = wr ? d : model[w];
    if (wr) model[w] = d;
    @(posedge clk);
    #1;
    acc_cyc[next_tag] = cyc;
    last_tag  = next_tag;
    req_valid = 1'b0;
    next_tag  = next_tag + 1'b1;
  endtask

  task automatic wait_idle();
    while (outstanding() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // watchdog
  initial begin
    while (cyc < 150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [TAG_W-1:0] ta, tb, tc, tfirst;
    int maxr;
    void'($urandom(32'd7));
    for (int i = 0; i < NWORDS; i++) model[i] = '0;
    for (int i = 0; i < 256; i++) pend[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R4: reset state
    chk(req_ready == 1'b1, "R4", "req_ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R4", "rsp_valid after reset", 64'(rsp_valid), 64'd0);

    // R6: idle-bank latency, and R9 reset content
    issue(0, 0, '0, 3'd0);
    ta = last_tag;
    wait_idle();
    chk(rsp_cyc[ta] - acc_cyc[ta] == BUSY + 1, "R6", "idle latency",
        64'(rsp_cyc[ta] - acc_cyc[ta]), 64'(BUSY + 1));

    // R7: two requests to bank 3 (words 3 and 130)
    issue(1, 3, 64'h1111, 3'd0);   ta = last_tag;
    issue(0, 130, '0, 3'd0);       tb = last_tag;
    wait_idle();
    chk(rsp_cyc[tb] - rsp_cyc[ta] >= BUSY, "R7", "same-bank spacing",
        64'(rsp_cyc[tb] - rsp_cyc[ta]), 64'(BUSY));

    // R8: bank 10 twice (words 10, 139), then bank 20
    issue(1, 10, 64'hAAAA, 3'd0);  ta = last_tag;
    issue(0, 139, '0, 3'd0);       tb = last_tag;
    issue(0, 20, '0, 3'd0);        tc = last_tag;
    wait_idle();
    chk(rsp_seq[tc] < rsp_seq[tb], "R8", "out-of-order completion",
        64'(rsp_seq[tc]), 64'(rsp_seq[tb]));

    // R5: five requests to bank 7 are taken, the sixth stalls
    rdy_mode = 1;
    issue(0, 7, '0, 3'd0);         ta = last_tag;
    issue(0, 134, '0, 3'd0);
    issue(0, 261, '0, 3'd0);
    issue(0, 388, '0, 3'd0);
    issue(0, 7, '0, 3'd0);         tb = last_tag;
    chk(acc_cyc[tb] - acc_cyc[ta] == 4, "R5", "five accepted back to back",
        64'(acc_cyc[tb] - acc_cyc[ta]), 64'd4);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {9'd7, 3'd0};
    #1;
    chk(req_ready == 1'b0, "R5", "sixth request stalls", 64'(req_ready), 64'd0);
    req_valid = 1'b0;
    rdy_mode = 0;
    issue(0, 7, '0, 3'd0);
    wait_idle();

    // R11: last grant bank 6; then banks 5, 2, 9 finish while stalled
    issue(0, 6, '0, 3'd0);
    wait_idle();
    rdy_mode = 1;
    issue(0, 5, '0, 3'd0);         ta = last_tag;
    issue(0, 2, '0, 3'd0);         tb = last_tag;
    issue(0, 9, '0, 3'd0);         tc = last_tag;
    repeat (30) @(negedge clk);
    rdy_mode = 0;
    wait_idle();
    chk(rsp_seq[ta] < rsp_seq[tc], "R11", "locked bank 5 first",
        64'(rsp_seq[ta]), 64'(rsp_seq[tc]));
    chk(rsp_seq[tc] < rsp_seq[tb], "R11", "bank 9 before bank 2",
        64'(rsp_seq[tc]), 64'(rsp_seq[tb]));

    // R1: byte-offset bits ignored
    issue(1, 40, 64'hFEED_0001, 3'd5);
    issue(0, 40, '0, 3'd0);        ta = last_tag;
    wait_idle();
    chk(got_data[ta] == 64'hFEED_0001, "R1", "offset bits ignored",
        got_data[ta], 64'hFEED_0001);

    // R3 and R4: stride-32 burst
    issue(0, 0, '0, 3'd0);         tfirst = last_tag;
    for (int k = 1; k < 16; k++) issue(0, 32 * k, '0, 3'd0);
    tb = last_tag;
    chk(acc_cyc[tb] - acc_cyc[tfirst] == 15, "R4", "one accept per cycle",
        64'(acc_cyc[tb] - acc_cyc[tfirst]), 64'd15);
    wait_idle();
    maxr = 0;
    for (int k = 0; k < 16; k++) begin
      logic [TAG_W-1:0] t = tfirst + TAG_W'(k);
      if (rsp_cyc[t] > maxr) maxr = rsp_cyc[t];
    end
    chk(maxr - acc_cyc[tfirst] <= 2 * BUSY + 16, "R3", "stride burst span",
        64'(maxr - acc_cyc[tfirst]), 64'(2 * BUSY + 16));

    // R2: full sweep, unique data per word
    for (int w = 0; w < NWORDS; w++) issue(1, w, {32'h5A5A_0000, 32'(w)}, 3'd0);
    for (int w = 0; w < NWORDS; w++) issue(0, w, '0, 3'd0);
    wait_idle();
    ta = last_tag;
    chk(got_data[ta] == {32'h5A5A_0000, 32'(NWORDS - 1)}, "R2", "last word of sweep",
        got_data[ta], {32'h5A5A_0000, 32'(NWORDS - 1)});

    // random traffic with random back-pressure (R9, R10)
    rdy_mode = 2;
    for (int n = 0; n < 3000; n++) begin
      int w = int'($urandom % NWORDS);
      bit wr = ($urandom % 2) == 1;
      issue(wr, w, {$urandom, $urandom}, 3'($urandom));
    end
    rdy_mode = 0;
    wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule